// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a small programmable logic array with ten output cells, configured by a flat vector of fuse bits. Twelve dedicated inputs and ten feedback signals, one for each output cell, form 22 array signals. Each signal enters the array both as itself and inverted, which gives 44 columns. Every product-term row ANDs together the columns whose fuses are intact. The rows are grouped by output cell. In each group, one row drives the cell's output enable and the remaining rows are ORed into the cell's sum. Two further rows are shared by all cells: one clears every register and one presets every register.

The configuration vector follows the conventional 5828-bit layout, so a configuration prepared for that layout evaluates as intended. Each output cell is either combinatorial or registered, and either active high or active low, chosen by two mode bits. The registers use the `clk` port. Dedicated input 0 still enters the array as an ordinary signal. Each bidirectional pin is split into a pad input, an output value and an output enable, which the surrounding pad logic resolves.

Top module: `sop_logic_array`

## Requirements
- R1: In `cfg`, a fuse bit of 0 means intact (column connected) and 1 means blown (column removed). A row with all 44 fuses intact evaluates to 0. A row with all 44 fuses blown evaluates to 1.
- R2: Row r occupies `cfg[44r+43:44r]`. Column 2p carries array signal p and column 2p+1 carries its inverse. For p < 20, even p is `ded_in[p/2]` and odd p is the feedback of output (p-1)/2. For p = 20 and p = 21 the signal is `ded_in[p-10]`.
- R3: When mode bit S1 = 1, output k is combinatorial. `io_out[k]` is the OR of its logic rows when S0 = 1, and the inverse of that OR when S0 = 0.
- R4: When S1 = 0, output k is registered. At each rising `clk` edge the register loads the OR of its logic rows, and `io_out[k]` is the register value (S0 = 1) or its inverse (S0 = 0).
- R5: `io_oe[k]` equals output k's enable row. The feedback of a combinatorial output is taken from `io_in[k]`.
- R6: Row 0 is the shared clear. While it is 1, every registered output immediately shows a register value of 0, and the next clock edge stores 0. Clear takes priority over preset.
- R7: Row 131 (first fuse 5764) is the shared preset. When it is 1 and the clear row is 0, the next clock edge stores 1 in every register.
- R8: Outputs 0 to 9 own 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 logic rows. The group for output k starts at row 1 + sum over j < k of (terms_j + 1), with the enable row first and the logic rows after it. Output 6 uses rows 83 to 97 and output 7 starts at row 98.
- R9: A synchronous active-high `rst` sets every register to 0 at the clock edge.
- R10: For output k, S0 is `cfg[5808+2k]` (1 = active high) and S1 is `cfg[5809+2k]` (1 = combinatorial).
- R11: The feedback of a registered output is the register value, independent of `io_in[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset of all registers |
| cfg | input | 5828 | Fuse array (132 x 44) followed by 20 mode bits |
| ded_in | input | 12 | Dedicated array inputs |
| io_in | input | 10 | Pad value of each bidirectional pin |
| io_out | output | 10 | Value driven toward each pin |
| io_oe | output | 10 | Output enable of each pin |

## Verification
On every cycle, the assertions check the register update rules: reset and the clear row give zero, the preset row gives all ones, and otherwise each register loads its sum. They also check that, while the clear row is active, every registered output shows the cleared value at the pin with the programmed polarity. The bench's scenarios are needed for what depends on a particular configuration: the fuse addressing and column order, the row group boundaries between neighbouring outputs, the mode bit positions, combinatorial feedback from the pad, and register feedback that ignores the pad.

// File: rtl/sop_pkg.sv
`timescale 1ns/1ps
package sop_pkg;

  // logic rows owned by output k: grows by step toward the middle cells
  function automatic int terms_of(input int k, input int n_out,
                                  input int base, input int step);
    int m;
    m = (k < (n_out - 1 - k)) ? k : (n_out - 1 - k);
    return base + step * m;
  endfunction

  // row index of output k's enable row (row 0 is the shared clear)
  function automatic int oe_row_of(input int k, input int n_out,
                                   input int base, input int step);
    int r;
    r = 1;
    for (int j = 0; j < k; j++) r += terms_of(j, n_out, base, step) + 1;
    return r;
  endfunction

  // all rows, including the shared clear and preset rows
  function automatic int row_total(input int n_out, input int base,
                                   input int step);
    return oe_row_of(n_out, n_out, base, step) + 1;
  endfunction

endpackage

// File: rtl/sop_column_map.sv
`timescale 1ns/1ps
module sop_column_map #(
  parameter int N_DED = 12,
  parameter int N_OUT = 10,
  localparam int N_SIG = N_DED + N_OUT,
  localparam int N_COL = 2 * N_SIG
) (
  input  logic [N_DED-1:0] ded_in,
  input  logic [N_OUT-1:0] fb,
  output logic [N_COL-1:0] cols
);
  logic [N_SIG-1:0] sig;

  for (genvar p = 0; p < N_SIG; p++) begin : g_pair
    if (p < 2 * N_OUT && (p % 2) == 0) begin : g_ded
      assign sig[p] = ded_in[p/2];
    end else if (p < 2 * N_OUT) begin : g_fb
      assign sig[p] = fb[(p-1)/2];
    end else begin : g_tail
      assign sig[p] = ded_in[p-N_OUT];
    end
    assign cols[2*p]   = sig[p];
    assign cols[2*p+1] = ~sig[p];
  end
endmodule

// File: rtl/sop_term_plane.sv
`timescale 1ns/1ps
module sop_term_plane #(
  parameter int N_ROW = 132,
  parameter int N_COL = 44
) (
  input  logic [N_ROW*N_COL-1:0] fuses,
  input  logic [N_COL-1:0]       cols,
  output logic [N_ROW-1:0]       terms
);
  // blown fuse (1) removes the column from the AND
  for (genvar r = 0; r < N_ROW; r++) begin : g_row
    assign terms[r] = &(fuses[r*N_COL +: N_COL] | cols);
  end
endmodule

// File: rtl/sop_out_cell.sv
`timescale 1ns/1ps
module sop_out_cell #(
  parameter int N_TERMS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_TERMS-1:0] sum_terms,
  input  logic               oe_term,
  input  logic               ar_hit,
  input  logic               sp_hit,
  input  logic               pol_high,
  input  logic               comb_mode,
  input  logic               pad_in,
  output logic               pin_val,
  output logic               pin_oe,
  output logic               fb_val,
  output logic               q_o,
  output logic               d_o
);
  logic sum_or;
  logic q_reg;
  logic q_vis;

  assign sum_or = |sum_terms;

  always_ff @(posedge clk) begin
    if (rst)         q_reg <= 1'b0;
    else if (ar_hit) q_reg <= 1'b0;
    else if (sp_hit) q_reg <= 1'b1;
    else             q_reg <= sum_or;
  end

  // clear row shows at the pin at once, ahead of the edge that stores it
  assign q_vis = q_reg & ~ar_hit;

  always_comb begin
    if (comb_mode) pin_val = pol_high ? sum_or : ~sum_or;
    else           pin_val = pol_high ? q_vis  : ~q_vis;
  end

  assign pin_oe = oe_term;
  assign fb_val = comb_mode ? pad_in : q_reg;
  assign q_o    = q_reg;
  assign d_o    = sum_or;
endmodule

// File: rtl/sop_logic_array.sv
`timescale 1ns/1ps
module sop_logic_array #(
  parameter int N_DED      = 12,
  parameter int N_OUT      = 10,
  parameter int BASE_TERMS = 8,
  parameter int TERM_STEP  = 2,
  localparam int N_SIG     = N_DED + N_OUT,
  localparam int N_COL     = 2 * N_SIG,
  localparam int N_ROW     = sop_pkg::row_total(N_OUT, BASE_TERMS, TERM_STEP),
  localparam int FUSE_BITS = N_ROW * N_COL,
  localparam int CFG_W     = FUSE_BITS + 2 * N_OUT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  input  logic [N_DED-1:0] ded_in,
  input  logic [N_OUT-1:0] io_in,
  output logic [N_OUT-1:0] io_out,
  output logic [N_OUT-1:0] io_oe
);
  logic [N_COL-1:0] cols;
  logic [N_ROW-1:0] terms;
  logic [N_OUT-1:0] fb;
  logic [N_OUT-1:0] q_state;
  logic [N_OUT-1:0] d_next;
  logic             ar_hit;
  logic             sp_hit;

  sop_column_map #(.N_DED(N_DED), .N_OUT(N_OUT)) u_cols (
    .ded_in (ded_in),
    .fb     (fb),
    .cols   (cols)
  );

  sop_term_plane #(.N_ROW(N_ROW), .N_COL(N_COL)) u_plane (
    .fuses (cfg[FUSE_BITS-1:0]),
    .cols  (cols),
    .terms (terms)
  );

  assign ar_hit = terms[0];
  assign sp_hit = terms[N_ROW-1];

  for (genvar k = 0; k < N_OUT; k++) begin : g_cell
    localparam int OE_R = sop_pkg::oe_row_of(k, N_OUT, BASE_TERMS, TERM_STEP);
    localparam int NT   = sop_pkg::terms_of(k, N_OUT, BASE_TERMS, TERM_STEP);

    sop_out_cell #(.N_TERMS(NT)) u_cell (
      .clk       (clk),
      .rst       (rst),
      .sum_terms (terms[OE_R+1 +: NT]),
      .oe_term   (terms[OE_R]),
      .ar_hit    (ar_hit),
      .sp_hit    (sp_hit),
      .pol_high  (cfg[FUSE_BITS + 2*k]),
      .comb_mode (cfg[FUSE_BITS + 2*k + 1]),
      .pad_in    (io_in[k]),
      .pin_val   (io_out[k]),
      .pin_oe    (io_oe[k]),
      .fb_val    (fb[k]),
      .q_o       (q_state[k]),
      .d_o       (d_next[k])
    );
  end
endmodule

// File: rtl/sop_logic_array_chk.sv
`timescale 1ns/1ps
module sop_logic_array_chk #(
  parameter int N_OUT     = 10,
  parameter int CFG_W     = 5828,
  parameter int MODE_BASE = 5808
) (
  input logic             clk,
  input logic             rst,
  input logic [CFG_W-1:0] cfg,
  input logic [N_OUT-1:0] io_out,
  input logic             ar_hit,
  input logic             sp_hit,
  input logic [N_OUT-1:0] q_state,
  input logic [N_OUT-1:0] d_next
);
  logic [N_OUT-1:0] s0v;
  logic [N_OUT-1:0] s1v;

  for (genvar k = 0; k < N_OUT; k++) begin : g_mode
    assign s0v[k] = cfg[MODE_BASE + 2*k];
    assign s1v[k] = cfg[MODE_BASE + 2*k + 1];
  end

  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (q_state == '0));

  assert_clear_stores_zero_R6: assert property (@(posedge clk) disable iff (rst)
    ar_hit |=> (q_state == '0));

  assert_preset_stores_ones_R7: assert property (@(posedge clk) disable iff (rst)
    (sp_hit && !ar_hit) |=> (q_state == '1));

  assert_register_loads_sum_R4: assert property (@(posedge clk) disable iff (rst)
    (!ar_hit && !sp_hit) |=> (q_state == $past(d_next)));

  assert_clear_visible_at_pin_R6: assert property (@(posedge clk) disable iff (rst)
    ar_hit |-> (((io_out ^ ~s0v) & ~s1v) == '0));
endmodule

bind sop_logic_array sop_logic_array_chk #(
  .N_OUT(N_OUT), .CFG_W(CFG_W), .MODE_BASE(FUSE_BITS)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cfg     (cfg),
  .io_out  (io_out),
  .ar_hit  (ar_hit),
  .sp_hit  (sp_hit),
  .q_state (q_state),
  .d_next  (d_next)
);

// File: tb/sim_sop_logic_array.sv
`timescale 1ns/1ps
module sim_sop_logic_array;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [5827:0] cfg;
  logic [11:0]   ded_in = '0;
  logic [9:0]    io_in  = '0;
  logic [9:0]    io_out;
  logic [9:0]    io_oe;

  int n_vec = 0;
  int n_bad = 0;
  logic b;

  always #2.5 clk = ~clk;

  sop_logic_array u0 (
    .clk(clk), .rst(rst), .cfg(cfg), .ded_in(ded_in),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe)
  );

  // {ded_in, io_in, expected io_out (bits 0,1,2,9), expected io_oe}
  localparam logic [41:0] VEC [10] = '{
    {12'h000, 10'h000, 10'h002, 10'h21D},
    {12'h003, 10'h000, 10'h003, 10'h21D},
    {12'h001, 10'h000, 10'h002, 10'h21D},
    {12'h004, 10'h000, 10'h003, 10'h21D},
    {12'h804, 10'h000, 10'h002, 10'h21D},
    {12'h018, 10'h000, 10'h000, 10'h21F},
    {12'h008, 10'h000, 10'h002, 10'h21F},
    {12'h000, 10'h001, 10'h006, 10'h21D},
    {12'h000, 10'h003, 10'h002, 10'h21D},
    {12'h400, 10'h000, 10'h202, 10'h21D}
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic blow_row(input int r);
    for (int c = 0; c < 44; c++) cfg[44*r + c] = 1'b1;
  endtask

  task automatic keep(input int r, input int c);
    cfg[44*r + c] = 1'b0;
  endtask

  task automatic build_cfg();
    cfg = '0;
    // out0 comb high: (d0 & d1) | (~d11 & d2)
    cfg[5808] = 1'b1; cfg[5809] = 1'b1;
    blow_row(1);
    blow_row(2);  keep(2, 0);  keep(2, 4);
    blow_row(3);  keep(3, 43); keep(3, 8);
    // out1 comb low: ~d4, enable d3
    cfg[5810] = 1'b0; cfg[5811] = 1'b1;
    blow_row(10); keep(10, 12);
    blow_row(11); keep(11, 16);
    // out2 comb high: pad0 & ~pad1
    cfg[5812] = 1'b1; cfg[5813] = 1'b1;
    blow_row(21);
    blow_row(22); keep(22, 2); keep(22, 7);
    // out3 registered high: D = d5
    cfg[5814] = 1'b1; cfg[5815] = 1'b0;
    blow_row(34);
    blow_row(35); keep(35, 20);
    // out4 registered low: D = ~q4 | (d6 & d7)
    blow_row(49);
    blow_row(50); keep(50, 19);
    blow_row(65); keep(65, 24); keep(65, 28);
    // out9 comb high: d10
    cfg[5826] = 1'b1; cfg[5827] = 1'b1;
    blow_row(122);
    blow_row(130); keep(130, 40);
    // clear: d8 & d9 ; preset: d8 & ~d9
    blow_row(0);   keep(0, 32);   keep(0, 36);
    blow_row(131); keep(131, 32); keep(131, 37);
  endtask

  task automatic drive(input logic [11:0] d, input logic [9:0] p);
    @(negedge clk);
    ded_in = d;
    io_in  = p;
    #1;
  endtask

  initial begin
    #(5.0 * 150000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    build_cfg();
    repeat (3) @(posedge clk);
    // R9: reset state just after release
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R9 reset registers", {22'd0, io_out & 10'h1F8}, {22'd0, 10'h1F0});
    check("R5 enables after reset", {22'd0, io_oe}, {22'd0, 10'h21D});

    // R2 R3 R5: combinatorial table
    for (int i = 0; i < 10; i++) begin
      drive(VEC[i][41:30], VEC[i][29:20]);
      check("R2/R3 comb vector", {22'd0, io_out & 10'h207}, {22'd0, VEC[i][19:10]});
      check("R5 enable vector", {22'd0, io_oe}, {22'd0, VEC[i][9:0]});
    end

    // R4: registered high follows d5
    drive(12'h020, 10'h000);
    @(posedge clk); #1;
    check("R4 reg load 1", {31'd0, io_out[3]}, 32'd1);
    drive(12'h000, 10'h000);
    @(posedge clk); #1;
    check("R4 reg load 0", {31'd0, io_out[3]}, 32'd0);

    // R11: toggling register ignores its pad input
    drive(12'h000, 10'h3FF);
    for (int t = 0; t < 2; t++) begin
      b = io_out[4];
      @(posedge clk); #1;
      check("R11 reg feedback toggle", {31'd0, io_out[4]}, {31'd0, ~b});
      io_in = ~io_in;
    end

    // R7: preset
    drive(12'h100, 10'h000);
    @(posedge clk); #1;
    check("R7 preset all", {22'd0, io_out & 10'h1F8}, {22'd0, 10'h008});

    // R6: clear, immediate then stored
    drive(12'h300, 10'h000);
    check("R6 clear immediate", {22'd0, io_out & 10'h1F8}, {22'd0, 10'h1F0});
    @(posedge clk); #1;
    check("R6 clear held", {22'd0, io_out & 10'h1F8}, {22'd0, 10'h1F0});
    drive(12'h000, 10'h000);
    check("R6 clear stored", {22'd0, io_out & 10'h1F8}, {22'd0, 10'h1F0});

    // R10: polarity bit of out9 at 5826
    @(negedge clk);
    cfg[5826] = 1'b0;
    #1;
    check("R10 polarity bit", {31'd0, io_out[9]}, 32'd1);
    cfg[5826] = 1'b1;

    // R1 R8: out6 as comb high, all rows intact
    @(negedge clk);
    cfg[5820] = 1'b1; cfg[5821] = 1'b1;
    #1;
    check("R1 intact rows give 0", {30'd0, io_oe[6], io_out[6]}, 32'd0);
    @(negedge clk);
    blow_row(97);
    #1;
    check("R1/R8 blown last row of out6", {31'd0, io_out[6]}, 32'd1);
    @(negedge clk);
    blow_row(83);
    #1;
    check("R5/R8 out6 enable row", {31'd0, io_oe[6]}, 32'd1);
    @(negedge clk);
    for (int c = 0; c < 44; c++) cfg[44*97 + c] = 1'b0;
    blow_row(98);
    #1;
    check("R8 row 98 belongs to out7", {30'd0, io_oe[7], io_out[6]}, 32'd2);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule